// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a memory-mapped SPI master for a larger chip. Software reaches five 32-bit registers through a simple strobe bus: control, status, transmit data, receive data and slave select. Each transmit data write goes into a transmit FIFO. A shift engine serialises the queued words onto the serial clock and data-out lines, and captures the data-in line into a receive FIFO that software drains by reading the receive data register. Eight of the ten control bits are ordinary read/write bits. They select clock polarity, clock phase, bit order and internal loopback, and they gate the engine through an enable, a master bit and a transmit-hold bit. The other two control bits are self-clearing FIFO flush bits.

The serial clock rate and the word width are fixed when the block is built. The serial clock half-period is a parameter counted in system clock cycles. The word width is 8, 16 or 32 bits. Software cannot change either one. The slave-select outputs are active low. They are driven from a register, either permanently (manual mode) or only while a transfer is in progress (automatic mode). A separate interrupt block receives two level flags and three single-cycle event pulses.

Top module: `spi_master_mmio`

## Requirements
- R1: The registers decode at byte offsets 0x60 control, 0x64 status, 0x68 transmit data, 0x6C receive data and 0x70 slave select. The control bits are: 0 loopback, 1 enable, 2 master, 3 clock polarity, 4 clock phase, 7 manual select, 8 transmit hold, 9 LSB-first. These bits read back as written. After reset the control register reads 0x100 and the slave-select register reads all ones.
- R2: The status register reads bit0 receive FIFO empty, bit1 receive FIFO full, bit2 transmit FIFO empty, bit3 transmit FIFO full and bit4 mode fault (always 0). All other status bits read 0.
- R3: Writing 1 to control bit 5 empties the transmit FIFO, and writing 1 to control bit 6 empties the receive FIFO. Both bits always read back as 0.
- R4: While control bit 8 is 1, the serial clock does not toggle, even if the transmit FIFO holds words. Clearing bit 8 sends all queued words back to back, each word taking exactly 2×width serial clock edges.
- R5: The serial clock idles at the polarity bit. With phase 0, data-out is sampled on the leading edge; with phase 1, it is sampled on the trailing edge. Words go out MSB first, or LSB first when bit 9 is 1.
- R6: With loopback 1, the received word equals the transmitted word, and the data-in pin is ignored. With loopback 0, the data-in pin is captured with the same edge timing and bit order.
- R7: A transmit data write uses only the low width bits. A receive data read returns the oldest word right-aligned with zero upper bits, and reads 0 when the receive FIFO is empty.
- R8: In manual mode (bit 7 = 1), the select outputs equal the slave-select register. In automatic mode, they equal the register from the start of the first queued word to the end of the last one, with no deassertion between words, and are all ones otherwise.
- R9: Both FIFOs are 16 words deep. A transmit write to a full FIFO is dropped and pulses evt_tx_drop_o. A word received while the receive FIFO is full is dropped and pulses evt_rx_drop_o.
- R10: evt_tx_done_o pulses for one cycle when a word finishes shifting and the transmit FIFO is empty. It does not pulse between back-to-back words.
- R11: lvl_tx_empty_o is high when the transmit FIFO is empty. lvl_rx_avail_o is high when the receive FIFO holds at least one word.
- R12: Transfers start only when enable and master are both 1 and the transmit hold is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe, one cycle per access |
| bus_rd_i | input | 1 | Register read strobe; a read of receive data pops the FIFO |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_no | output | NUM_SS | Active-low slave selects |
| lvl_tx_empty_o | output | 1 | Transmit FIFO empty level |
| lvl_rx_avail_o | output | 1 | Receive FIFO non-empty level |
| evt_tx_done_o | output | 1 | Pulse: last queued word finished |
| evt_tx_drop_o | output | 1 | Pulse: transmit write dropped on a full FIFO |
| evt_rx_drop_o | output | 1 | Pulse: received word dropped on a full FIFO |

## Verification
The bench sweeps all four clock modes, both bit orders and both loopback settings. In each configuration it checks the bits seen on the wire against the bit order, and the data it reads back against the written word or its inverse, because data-in is tied to the inverse of data-out. An engine that sampled on the wrong edge or reversed the wrong word would show shifted or mirrored bytes, and a loopback multiplexer that was stuck would return the inverse. The bench holds words under the transmit hold and counts clock edges, which exposes an engine that starts early or runs an extra edge. It also watches the selects across word boundaries, which catches a select that drops between words. Filling both FIFOs to exactly 16 words and pushing one more checks the drop pulses and the full flags, where an off-by-one depth would either lose the sixteenth word or accept the seventeenth.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam logic [7:0] OFF_CTRL = 8'h60;
  localparam logic [7:0] OFF_STAT = 8'h64;
  localparam logic [7:0] OFF_TXD  = 8'h68;
  localparam logic [7:0] OFF_RXD  = 8'h6C;
  localparam logic [7:0] OFF_SEL  = 8'h70;

  localparam int CB_LOOP  = 0;
  localparam int CB_EN    = 1;
  localparam int CB_MST   = 2;
  localparam int CB_CPOL  = 3;
  localparam int CB_CPHA  = 4;
  localparam int CB_TXCLR = 5;
  localparam int CB_RXCLR = 6;
  localparam int CB_MAN   = 7;
  localparam int CB_HOLD  = 8;
  localparam int CB_LSB   = 9;
  localparam int CTRL_W   = 10;

  localparam logic [CTRL_W-1:0] CTRL_RST  = 10'h100;
  localparam logic [CTRL_W-1:0] CTRL_KEEP = 10'h39F;

  typedef enum logic {SH_IDLE, SH_RUN} sh_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] din_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] dout_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign dout_o  = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (flush_i) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
    end else begin
      if (push_i) wr_d = (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      if (pop_i)  rd_d = (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      if (push_i && !pop_i) cnt_d = cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !flush_i) mem_q[wr_q] <= din_i;
  end

  // R9: the owner never pushes into a full FIFO unless a pop frees a slot
  assert_no_overflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o) |-> pop_i);
  // R9: the owner never pops an empty FIFO
  assert_no_underflow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/spim_shift.sv
module spim_shift import spim_pkg::*; #(
  parameter int WORD_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              have_word_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              lsb_i,
  input  logic              miso_i,
  output logic              pop_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  localparam int EDGES = 2 * WORD_W;
  localparam int EW    = $clog2(EDGES);
  localparam int DW    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);
  localparam logic [DW-1:0] DIV_TOP   = DW'(HALF_DIV - 1);

  sh_state_e st_q, st_d;
  logic [DW-1:0] div_q, div_d;
  logic [EW-1:0] edge_q, edge_d;
  logic phase_q, phase_d;
  logic [WORD_W-1:0] sr_q, sr_d, rx_q, rx_d, rxw_q, rxw_d;
  logic done_q, done_d;
  logic start, tick, lead, last, smp, shf;
  logic [WORD_W-1:0] word_rev, rx_rev;

  assign start     = (st_q == SH_IDLE) && run_i && have_word_i;
  assign tick      = (div_q == DIV_TOP);
  assign lead      = !edge_q[0];
  assign last      = (edge_q == LAST_EDGE);
  assign smp       = cpha_i ? !lead : lead;
  assign shf       = cpha_i ? (lead && (edge_q != '0)) : (!lead && !last);
  assign pop_o     = start;
  assign busy_o    = (st_q == SH_RUN) || start;
  assign mosi_o    = sr_q[WORD_W-1];
  assign sclk_o    = cpol_i ^ phase_q;
  assign done_o    = done_q;
  assign rx_word_o = rxw_q;

  always_comb begin
    st_d    = st_q;
    div_d   = div_q;
    edge_d  = edge_q;
    phase_d = phase_q;
    sr_d    = sr_q;
    rx_d    = rx_q;
    rxw_d   = rxw_q;
    done_d  = 1'b0;
    for (int i = 0; i < WORD_W; i++) word_rev[i] = word_i[WORD_W-1-i];
    if (st_q == SH_IDLE) begin
      if (start) begin
        st_d    = SH_RUN;
        div_d   = '0;
        edge_d  = '0;
        phase_d = 1'b0;
        rx_d    = '0;
        sr_d    = lsb_i ? word_rev : word_i;
      end
    end else begin
      div_d = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        phase_d = !phase_q;
        if (smp) rx_d = {rx_q[WORD_W-2:0], miso_i};
        if (shf) sr_d = {sr_q[WORD_W-2:0], 1'b0};
        if (last) begin
          st_d   = SH_IDLE;
          done_d = 1'b1;
        end else begin
          edge_d = edge_q + 1'b1;
        end
      end
    end
    for (int i = 0; i < WORD_W; i++) rx_rev[i] = rx_d[WORD_W-1-i];
    if (done_d) rxw_d = lsb_i ? rx_rev : rx_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SH_IDLE;
      div_q   <= '0;
      edge_q  <= '0;
      phase_q <= 1'b0;
      sr_q    <= '0;
      rx_q    <= '0;
      rxw_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      div_q   <= div_d;
      edge_q  <= edge_d;
      phase_q <= phase_d;
      sr_q    <= sr_d;
      rx_q    <= rx_d;
      rxw_q   <= rxw_d;
      done_q  <= done_d;
    end
  end

  // R4: an idle engine without permission to run stays idle
  assert_hold_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SH_IDLE && !run_i) |=> (st_q == SH_IDLE));
  // R5: between words the serial clock rests at the polarity level
  assert_sclk_rest_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == SH_IDLE) |-> (sclk_o == cpol_i));
endmodule

// File: rtl/spi_master_mmio.sv
module spi_master_mmio import spim_pkg::*; #(
  parameter int WORD_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int HALF_DIV   = 2,
  parameter int NUM_SS     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [7:0]        bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_SS-1:0] ss_no,
  output logic              lvl_tx_empty_o,
  output logic              lvl_rx_avail_o,
  output logic              evt_tx_done_o,
  output logic              evt_tx_drop_o,
  output logic              evt_rx_drop_o
);
  logic [1:0] rst_sync_q;
  logic rst_n;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [NUM_SS-1:0] sel_q, sel_d;
  logic wr_ctrl, wr_txd, wr_sel, rd_rxd;
  logic tx_flush, rx_flush, tx_push, tx_pop, rx_push, rx_pop;
  logic tx_empty, tx_full, rx_empty, rx_full;
  logic [WORD_W-1:0] tx_head, rx_head, rx_word;
  logic sh_busy, sh_done, sh_mosi, run, miso_int;
  logic [31:0] rxd_ext, sel_ext;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign wr_ctrl = bus_wr_i && (bus_addr_i == OFF_CTRL);
  assign wr_txd  = bus_wr_i && (bus_addr_i == OFF_TXD);
  assign wr_sel  = bus_wr_i && (bus_addr_i == OFF_SEL);
  assign rd_rxd  = bus_rd_i && (bus_addr_i == OFF_RXD);

  assign tx_flush = wr_ctrl && bus_wdata_i[CB_TXCLR];
  assign rx_flush = wr_ctrl && bus_wdata_i[CB_RXCLR];
  assign tx_push  = wr_txd && !tx_full;
  assign rx_pop   = rd_rxd && !rx_empty;
  assign rx_push  = sh_done && (!rx_full || rx_pop);

  always_comb begin
    ctrl_d = ctrl_q;
    sel_d  = sel_q;
    if (wr_ctrl) ctrl_d = bus_wdata_i[CTRL_W-1:0] & CTRL_KEEP;
    if (wr_sel)  sel_d  = bus_wdata_i[NUM_SS-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      sel_q  <= '1;
    end else begin
      ctrl_q <= ctrl_d;
      sel_q  <= sel_d;
    end
  end

  assign run      = ctrl_q[CB_EN] && ctrl_q[CB_MST] && !ctrl_q[CB_HOLD];
  assign miso_int = ctrl_q[CB_LOOP] ? sh_mosi : miso_i;

  spim_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_txf (
    .clk_i(clk_i), .rst_ni(rst_n), .flush_i(tx_flush),
    .push_i(tx_push), .din_i(bus_wdata_i[WORD_W-1:0]),
    .pop_i(tx_pop), .dout_o(tx_head), .empty_o(tx_empty), .full_o(tx_full));

  spim_fifo #(.WIDTH(WORD_W), .DEPTH(FIFO_DEPTH)) u_rxf (
    .clk_i(clk_i), .rst_ni(rst_n), .flush_i(rx_flush),
    .push_i(rx_push), .din_i(rx_word),
    .pop_i(rx_pop), .dout_o(rx_head), .empty_o(rx_empty), .full_o(rx_full));

  spim_shift #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_n), .run_i(run), .have_word_i(!tx_empty),
    .word_i(tx_head), .cpol_i(ctrl_q[CB_CPOL]), .cpha_i(ctrl_q[CB_CPHA]),
    .lsb_i(ctrl_q[CB_LSB]), .miso_i(miso_int), .pop_o(tx_pop),
    .sclk_o(sclk_o), .mosi_o(sh_mosi), .busy_o(sh_busy), .done_o(sh_done),
    .rx_word_o(rx_word));

  assign mosi_o = sh_mosi;
  assign ss_no  = (ctrl_q[CB_MAN] || sh_busy) ? sel_q : '1;

  assign lvl_tx_empty_o = tx_empty;
  assign lvl_rx_avail_o = !rx_empty;
  assign evt_tx_done_o  = sh_done && tx_empty;
  assign evt_tx_drop_o  = wr_txd && tx_full;
  assign evt_rx_drop_o  = sh_done && rx_full && !rx_pop;

  always_comb begin
    rxd_ext = '0;
    sel_ext = '0;
    if (!rx_empty) rxd_ext[WORD_W-1:0] = rx_head;
    sel_ext[NUM_SS-1:0] = sel_q;
    case (bus_addr_i)
      OFF_CTRL: bus_rdata_o = {{(32-CTRL_W){1'b0}}, ctrl_q};
      OFF_STAT: bus_rdata_o = {27'b0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
      OFF_RXD:  bus_rdata_o = rxd_ext;
      OFF_SEL:  bus_rdata_o = sel_ext;
      default:  bus_rdata_o = '0;
    endcase
  end

  // R10: the done event only fires once the engine has nothing left to send
  assert_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_n)
    evt_tx_done_o |-> !sh_busy);
  // R12: the engine never pops a word while it lacks permission to run
  assert_pop_needs_run_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    tx_pop |-> (ctrl_q[CB_EN] && ctrl_q[CB_MST] && !ctrl_q[CB_HOLD]));
endmodule

// File: tb/spi_master_mmio_tb.sv
module spi_master_mmio_tb;
  localparam int W = 8;
  localparam int NSS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic sclk, mosi, miso;
  logic [NSS-1:0] ss_n;
  logic lvl_txe, lvl_rxa, evt_done, evt_txdrop, evt_rxdrop;

  int n_tests = 0, n_fail = 0;
  int done_cnt = 0, txdrop_cnt = 0, rxdrop_cnt = 0;
  int edge_cnt = 0;
  bit mon_en = 0, mon_cpol = 0, mon_cpha = 0;
  logic [W-1:0] mon_cap;
  int mon_bits = 0, mon_n = 0;
  logic [W-1:0] mon_words [0:31];
  bit finished = 0;

  always #4 clk = ~clk;
  assign miso = ~mosi;

  spi_master_mmio #(.WORD_W(W), .FIFO_DEPTH(16), .HALF_DIV(2), .NUM_SS(NSS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_no(ss_n),
    .lvl_tx_empty_o(lvl_txe), .lvl_rx_avail_o(lvl_rxa), .evt_tx_done_o(evt_done),
    .evt_tx_drop_o(evt_txdrop), .evt_rx_drop_o(evt_rxdrop));

  always @(posedge clk) begin
    if (evt_done)   done_cnt++;
    if (evt_txdrop) txdrop_cnt++;
    if (evt_rxdrop) rxdrop_cnt++;
  end

  always @(sclk) begin
    if (mon_en) begin
      edge_cnt++;
      if ((sclk != mon_cpol) == !mon_cpha) begin
        mon_cap = {mon_cap[W-2:0], mosi};
        mon_bits++;
        if (mon_bits == W) begin
          if (mon_n < 32) mon_words[mon_n] = mon_cap;
          mon_n++;
          mon_bits = 0;
        end
      end
    end
  end

  function automatic logic [W-1:0] brev(input logic [W-1:0] x);
    for (int i = 0; i < W; i++) brev[i] = x[W-1-i];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wait_done(input int target, input logic [NSS-1:0] sel, output bit glitch);
    bit seen = 0;
    glitch = 0;
    for (int c = 0; c < 4000 && done_cnt < target; c++) begin
      @(negedge clk);
      if (ss_n != '1) begin
        seen = 1;
        if (ss_n != sel) glitch = 1;
      end else if (seen && !evt_done && done_cnt < target) glitch = 1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit gl;
    int base;
    idle(5);
    rst_n = 1'b1;
    idle(5);

    // R1 R2 R11 reset state
    bus_read(8'h60, rd); check(rd == 32'h100, "R1 ctrl reset", rd, 32'h100);
    bus_read(8'h70, rd); check(rd == 32'hF, "R1 select reset", rd, 32'hF);
    bus_read(8'h64, rd); check(rd == 32'h5, "R2 status reset", rd, 32'h5);
    check(ss_n == 4'hF, "R8 selects idle", ss_n, 32'hF);
    check(sclk == 1'b0, "R5 sclk reset", sclk, 0);
    check(lvl_txe && !lvl_rxa, "R11 levels reset", {lvl_txe, lvl_rxa}, 32'h2);

    // R1 R3 control read back, self-clearing flush bits
    bus_write(8'h60, 32'h39F); bus_read(8'h60, rd);
    check(rd == 32'h39F, "R1 ctrl readback", rd, 32'h39F);
    bus_write(8'h60, 32'hFFFF_FFFF); bus_read(8'h60, rd);
    check(rd == 32'h39F, "R3 flush bits read 0", rd, 32'h39F);

    // R8 manual select
    bus_write(8'h60, 32'h080); bus_write(8'h70, 32'hD); idle(1);
    check(ss_n == 4'hD, "R8 manual select", ss_n, 32'hD);
    bus_read(8'h70, rd); check(rd == 32'hD, "R1 select readback", rd, 32'hD);
    bus_write(8'h70, 32'hF); idle(1);
    check(ss_n == 4'hF, "R8 manual deselect", ss_n, 32'hF);

    // R12 enable and master both needed
    edge_cnt = 0; mon_en = 1;
    bus_write(8'h60, 32'h004); bus_write(8'h68, 32'h5A); idle(60);
    bus_read(8'h64, rd); check(rd == 32'h1, "R12 master only holds", rd, 32'h1);
    bus_write(8'h60, 32'h002); idle(60);
    check(edge_cnt == 0, "R12 no clock without both", edge_cnt, 0);
    bus_write(8'h60, 32'h022); bus_read(8'h64, rd);
    check(rd == 32'h5, "R3 tx flush", rd, 32'h5);
    mon_en = 0;
    bus_write(8'h60, 32'h007); bus_write(8'h68, 32'h3C);
    wait_done(done_cnt + 1, 4'hF, gl);
    bus_read(8'h64, rd); check(rd == 32'h4, "R11 rx holds word", rd, 32'h4);
    check(lvl_rxa, "R11 rx avail level", lvl_rxa, 1);
    bus_write(8'h60, 32'h047); bus_read(8'h64, rd);
    check(rd == 32'h5, "R3 rx flush", rd, 32'h5);
    bus_read(8'h60, rd); check(rd == 32'h007, "R3 rx flush bit reads 0", rd, 32'h7);

    // sweep: mode, bit order, loopback
    for (int cfg = 0; cfg < 16; cfg++) begin
      logic [W-1:0] w [3];
      logic [NSS-1:0] sel;
      int dstart, ctl;
      for (int k = 0; k < 3; k++) w[k] = W'(cfg * 37 + k * 91 + 5);
      sel = ~(NSS'(1) << (cfg % NSS));
      ctl = 32'h006 | ((cfg & 1) << 3) | (((cfg >> 1) & 1) << 4) |
            (((cfg >> 2) & 1) << 9) | ((cfg >> 3) & 1);
      bus_write(8'h70, 32'(sel));
      bus_write(8'h60, ctl | 32'h100);
      mon_cpol = cfg[0]; mon_cpha = cfg[1];
      edge_cnt = 0; mon_n = 0; mon_bits = 0; mon_en = 1;
      for (int k = 0; k < 3; k++) bus_write(8'h68, 32'hDEAD_0000 | 32'(w[k]));
      dstart = done_cnt;
      idle(40);
      check(edge_cnt == 0, "R4 held clock still", edge_cnt, 0);
      check(sclk == cfg[0], "R5 idle level", sclk, cfg[0]);
      check(ss_n == 4'hF, "R8 auto idle deselect", ss_n, 32'hF);
      check(done_cnt == dstart, "R10 no done while held", done_cnt, dstart);
      bus_write(8'h60, ctl);
      wait_done(dstart + 1, sel, gl);
      idle(2);
      mon_en = 0;
      check(!gl, "R8 select held across words", gl, 0);
      check(done_cnt == dstart + 1, "R10 one done per batch", done_cnt, dstart + 1);
      check(edge_cnt == 3 * 2 * W, "R4 edge count", edge_cnt, 3 * 2 * W);
      check(ss_n == 4'hF, "R8 deselect after", ss_n, 32'hF);
      for (int k = 0; k < 3; k++) begin
        logic [W-1:0] wire_exp, rx_exp;
        wire_exp = cfg[2] ? brev(w[k]) : w[k];
        rx_exp = cfg[3] ? w[k] : ~w[k];
        check(mon_words[k] == wire_exp, "R5 wire bit order", mon_words[k], wire_exp);
        bus_read(8'h6C, rd);
        check(rd == 32'(rx_exp), "R6 R7 received word", rd, 32'(rx_exp));
      end
      bus_read(8'h64, rd); check(rd == 32'h5, "R2 status drained", rd, 32'h5);
    end

    // R9 depth and drops
    bus_write(8'h70, 32'hE);
    bus_write(8'h60, 32'h107);
    base = txdrop_cnt;
    for (int k = 0; k < 17; k++) bus_write(8'h68, 32'((k * 29 + 7) & 8'hFF));
    check(txdrop_cnt == base + 1, "R9 tx drop pulse", txdrop_cnt, base + 1);
    bus_read(8'h64, rd); check(rd == 32'h9, "R9 tx full status", rd, 32'h9);
    check(!lvl_txe, "R11 tx level", lvl_txe, 0);
    base = done_cnt;
    bus_write(8'h60, 32'h007);
    wait_done(base + 1, 4'hE, gl);
    check(!gl, "R8 select held 16 words", gl, 0);
    bus_read(8'h64, rd); check(rd == 32'h6, "R9 rx full status", rd, 32'h6);
    base = rxdrop_cnt;
    bus_write(8'h68, 32'hFF);
    wait_done(done_cnt + 1, 4'hE, gl);
    check(rxdrop_cnt == base + 1, "R9 rx drop pulse", rxdrop_cnt, base + 1);
    for (int k = 0; k < 16; k++) begin
      bus_read(8'h6C, rd);
      check(rd == 32'((k * 29 + 7) & 8'hFF), "R9 rx order", rd, 32'((k * 29 + 7) & 8'hFF));
    end
    bus_read(8'h6C, rd); check(rd == 32'h0, "R7 empty read zero", rd, 0);
    bus_read(8'h64, rd); check(rd == 32'h5, "R2 status final", rd, 32'h5);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule